// File: doc/BRIEF.md
# Idle Gap Predictor for Power-Down

This block watches the request and completion strobes of one memory device. It measures each idle gap, counted from the completion that ends a run of requests to the next request. It keeps the last four gap lengths and predicts the next gap as their average. Each time a gap opens, it compares that prediction with a configured break-even constant. The constant is the sum of the two transition times plus the minimum low-power residence that pays for them, and it is computed offline.

If the predicted gap is longer than the constant, the block issues its go-low command at once. If it is not, the block falls back to an ordinary idle timer: it commands the low state only after the gap has lasted the configured threshold. A request that arrives first cancels the command. Going low at once saves the most energy, but the device must climb back up before it can serve the next access, and that wake-up delay is the price of a wrong prediction. One instance sits beside each device's power-state controller.

Top module: `idle_gap_predictor`

## Requirements
- R1: During and after reset, `go_low_o` is 0, no gaps are on record, and no gap is open.
- R2: A pulse on `done_i` opens a gap. A later pulse on `req_i` closes it, and the recorded length is the number of clock edges from the edge that samples `done_i` to the edge that samples `req_i`. A request one cycle after the completion records 1.
- R3: Until four gaps have been recorded after reset, the immediate path is disabled and every gap uses the idle timer, whatever the gap lengths are.
- R4: Once four gaps are on record, the prediction is floor(sum of the last four lengths / 4). If the prediction is strictly greater than `boundary_i` at the edge that samples `done_i`, `go_low_o` is high for the one cycle that follows that edge.
- R5: A prediction equal to `boundary_i` does not use the immediate path. The idle timer is used instead.
- R6: On the timer path, `go_low_o` goes high for one cycle right after the edge that lies `fallback_i` edges past the opening edge. A value of 0 in `fallback_i` acts as 1.
- R7: If a request is sampled at or before the edge where the timer would fire, that gap produces no `go_low_o` pulse.
- R8: Each gap produces at most one `go_low_o` pulse, and `go_low_o` is never high while no gap is open.
- R9: The gap counter stops at 2^GAP_W−1 and does not wrap. A longer gap is recorded as that maximum value.
- R10: If `req_i` and `done_i` are sampled at the same edge while a gap is open, the old gap is closed and recorded, and a new gap opens. The decision for the new gap uses the history as it stood before that edge.
- R11: A request sampled while no gap is open records nothing and leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle strobe: a request has arrived |
| done_i | input | 1 | One-cycle strobe: the last request of a run has completed |
| boundary_i | input | GAP_W | Break-even gap length in cycles; the prediction must exceed it |
| fallback_i | input | GAP_W | Idle-timer threshold in cycles; 0 acts as 1 |
| go_low_o | output | 1 | One-cycle command to enter the low-power state |

## Verification
Two events can collide in a single cycle. The first collision is a request that closes one gap arriving together with the completion that opens the next. The bench drives both strobes in the same cycle, and its model makes the decision for the new gap from the old four lengths. The old history is chosen so that including the just-closed short gap would flip the outcome. The second collision is a request landing exactly on the edge where the idle timer would fire. For that case the bench expects no pulse in any cycle of that gap.

// File: rtl/idle_gap_predictor.sv
module idle_gap_predictor #(
  parameter int GAP_W   = 16,
  parameter int HIST_LG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             done_i,
  input  logic [GAP_W-1:0] boundary_i,
  input  logic [GAP_W-1:0] fallback_i,
  output logic             go_low_o
);
  localparam int HIST_N = 1 << HIST_LG;
  localparam int SUM_W  = GAP_W + HIST_LG;
  localparam int FILL_W = HIST_LG + 1;
  localparam logic [GAP_W-1:0]  CNT_MAX = {GAP_W{1'b1}};
  localparam logic [FILL_W-1:0] FULL    = FILL_W'(HIST_N);

  logic              idle_q, fired_q, go_low_q;
  logic [GAP_W-1:0]  cnt_q;
  logic [FILL_W-1:0] fill_q;
  logic [GAP_W-1:0]  hist_q [HIST_N];
  logic [SUM_W-1:0]  sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < HIST_N; i++) sum = sum + SUM_W'(hist_q[i]);
  end

  wire             warm    = (fill_q == FULL);
  wire [GAP_W-1:0] pred    = sum[SUM_W-1:HIST_LG];
  wire             jump    = warm && (pred > boundary_i);
  wire [GAP_W-1:0] fb_eff  = (fallback_i == '0) ? GAP_W'(1) : fallback_i;
  wire             record  = idle_q && req_i;
  wire             cnt_sat = (cnt_q == CNT_MAX);
  wire             timeout = idle_q && !fired_q && !req_i && !done_i && (cnt_q >= fb_eff);

  assign go_low_o = go_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= 1'b0;
      fired_q  <= 1'b0;
      go_low_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      go_low_q <= done_i ? jump : timeout;
      if (done_i) begin
        idle_q  <= 1'b1;
        cnt_q   <= GAP_W'(1);
        fired_q <= jump;
      end else if (req_i) begin
        idle_q  <= 1'b0;
        fired_q <= 1'b0;
      end else if (idle_q) begin
        if (!cnt_sat) cnt_q <= cnt_q + GAP_W'(1);
        if (timeout) fired_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   fill_q <= '0;
    else if (record && !warm)     fill_q <= fill_q + FILL_W'(1);
  end

  for (genvar i = 0; i < HIST_N; i++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist_q[i] <= '0;
      else if (record) hist_q[i] <= (i == 0) ? cnt_q : hist_q[(i == 0) ? 0 : i-1];
    end
  end

  AST_GAP_OPEN:  assert property (@(posedge clk) disable iff (!rst_n)
                   done_i |=> (idle_q && cnt_q == GAP_W'(1)));                        // R2
  AST_COLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
                   (done_i && !warm && fb_eff > GAP_W'(1)) |=> !go_low_q);           // R3
  AST_JUMP_WHY:  assert property (@(posedge clk) disable iff (!rst_n)
                   (go_low_q && $past(done_i)) |-> $past(warm && pred > boundary_i)); // R4
  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                   (req_i && !done_i) |=> !go_low_q);                                // R7
  AST_ONE_SHOT:  assert property (@(posedge clk) disable iff (!rst_n)
                   (go_low_q && !done_i) |=> !go_low_q);                             // R8
  AST_IDLE_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
                   go_low_q |-> idle_q);                                             // R8
  AST_SAT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                   (idle_q && cnt_sat && !done_i && !req_i) |=> cnt_q == CNT_MAX);   // R9
  AST_STRAY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                   (req_i && !idle_q && !done_i) |=> $stable(fill_q));               // R11
endmodule

// File: tb/idle_gap_predictor_tb.sv
module idle_gap_predictor_tb_top;
  localparam int GW  = 6;
  localparam int MAX = (1 << GW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, req_i = 1'b0, done_i = 1'b0;
  logic [GW-1:0] boundary_i = '0, fallback_i = '0;
  logic go_low_o;

  idle_gap_predictor #(.GAP_W(GW), .HIST_LG(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
    .boundary_i(boundary_i), .fallback_i(fallback_i), .go_low_o(go_low_o));

  always #2 clk = ~clk;

  typedef struct { int cyc; string tag; } exp_t;
  exp_t q[$];
  int hq[$];
  int cyc = 0, nchk = 0, nfail = 0, D = 0, Dn = 0;
  bit pend = 0, done_run = 0;
  string ctx = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bit e;
    string t;
    e = 0; t = ctx;
    if (q.size() > 0 && q[0].cyc == cyc) begin
      e = 1; t = q[0].tag; void'(q.pop_front());
    end
    if (!done_run) begin
      nchk++;
      if (go_low_o !== e) begin
        nfail++;
        $display("FAIL %s cycle %0d go_low_o=%0b expected %0b", t, cyc, go_low_o, e);
      end
    end
  end

  function automatic int pred();
    int s = 0;
    for (int i = 0; i < 4; i++) s += hq[i];
    return s / 4;
  endfunction

  function automatic void decide(int dv, int nv);
    int fe = (fallback_i == 0) ? 1 : int'(fallback_i);
    if (hq.size() >= 4 && pred() > int'(boundary_i)) q.push_back('{dv, ctx});
    else if (fe < nv) q.push_back('{dv + fe, ctx});
  endfunction

  task automatic gap(int n, int nxt = 0);
    if (!pend) begin
      @(negedge clk); done_i = 1; D = cyc + 1; decide(D, n);
      @(negedge clk); done_i = 0;
    end
    pend = 0;
    while (cyc < D + n - 1) @(negedge clk);
    req_i = 1;
    if (nxt > 0) begin done_i = 1; Dn = cyc + 1; decide(Dn, nxt); pend = 1; end
    hq.push_front(n > MAX ? MAX : n);
    if (hq.size() > 4) void'(hq.pop_back());
    @(negedge clk); req_i = 0; done_i = 0;
    if (pend) D = Dn; else repeat (2) @(negedge clk);
  endtask

  task automatic stray();
    @(negedge clk); req_i = 1;
    @(negedge clk); req_i = 0;
  endtask

  task automatic finish_run();
    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    ctx = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    ctx = "R3"; fallback_i = 5; boundary_i = 3;
    repeat (4) gap(20);
    ctx = "R4"; gap(20);

    ctx = "R7"; boundary_i = 60;
    gap(3); gap(5); gap(6);
    ctx = "R6"; fallback_i = 0; gap(4); fallback_i = 5;

    ctx = "R2"; boundary_i = 60;
    repeat (4) gap(8);
    ctx = "R5"; boundary_i = 8; gap(8);
    ctx = "R4"; boundary_i = 7; gap(9);
    ctx = "R2"; boundary_i = 60; gap(9); gap(9); gap(10);
    ctx = "R5"; boundary_i = 9; gap(12);
    ctx = "R4"; boundary_i = 9; gap(12);

    ctx = "R9"; fallback_i = MAX; boundary_i = 62;
    repeat (4) gap(80);
    ctx = "R8"; gap(70);

    ctx = "R10"; fallback_i = 5; boundary_i = 60;
    repeat (4) gap(40);
    boundary_i = 30;
    gap(2, 10);
    gap(10);

    ctx = "R11"; boundary_i = 60;
    repeat (3) gap(40);
    gap(2);
    boundary_i = 29;
    repeat (4) stray();
    gap(12);

    repeat (10) @(negedge clk);
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R8 pending expectations=%0d expected 0", q.size());
    end
    finish_run();
  end
endmodule